// File: doc/BRIEF.md
# Pipelined Floating-Point Multiplier

This block multiplies two numbers held in a compact floating-point format whose exponent width `WE` and mantissa width `WM` are fixed at elaboration. A word is laid out MSB first as `{sign, exponent[WE-1:0], mantissa[WM-1:0]}`. The mantissa is stored in full, with no hidden bit, as a fraction 0.1xxx. A word therefore stands for (-1)^sign × (mantissa / 2^WM) × 2^(exponent − bias), where bias = 2^(WE−1) − 1. A mantissa of all zeros encodes zero. The format has no infinities, no NaNs and no subnormals.

The datapath is a three-register pipeline and accepts a new operand pair on every clock. The first register stage holds the sign, the exponent sum, a zero-operand flag and the operand mantissas. The second holds the full-width mantissa product, which is written as an ordinary multiply so that synthesis may retime it into a hard multiplier or build it from logic, together with the unbiased exponent. The third normalizes, rounds to nearest with ties to even, tests the exponent range and saturates. Because both mantissas lie in [0.5, 1), the product lies in [0.25, 1). Normalization is therefore only a one-bit left shift with an exponent decrement, chosen by the top product bit. `WM` must be at least 3.

Top module: `fpm_mult`

## Requirements
- R1: `out_valid` repeats `in_valid` exactly three clock edges later, and a new operand pair is accepted on every cycle.
- R2: For a nonzero result inside the exponent range, `p_sign` is the XOR of the two operand signs.
- R3: With the top product bit set, the exponent is ea + eb − bias. With it clear, the exponent is ea + eb − bias − 1 and the product is shifted left by one. Every result that is not zero has mantissa bit WM−1 set.
- R4: Before rounding, the result mantissa is the upper WM bits of the normalized 2·WM-bit product.
- R5: The kept mantissa is incremented when the guard bit is 1 and at least one of the round bit, the sticky bit (OR of the remaining discarded bits) or the kept LSB is 1. An exact half therefore rounds to the even mantissa.
- R6: If rounding carries out of the mantissa, the mantissa becomes 1 followed by zeros and the exponent is incremented. The range tests of R7 and R8 use this final exponent.
- R7: A final exponent above 2^WE − 1 gives all-ones exponent and mantissa with the XOR sign, and raises `ovf_flag`.
- R8: A final exponent below 0 gives an all-zero word (sign included) and raises `unf_flag`.
- R9: If either operand mantissa is all zeros, the result is an all-zero word with no flag raised, whatever the exponents are.
- R10: Reset clears `out_valid`, all result fields and both flags. The flags are only ever raised together with `out_valid`, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 1+WE+WM | First operand word |
| op_b | input | 1+WE+WM | Second operand word |
| out_valid | output | 1 | Result present |
| p_sign | output | 1 | Result sign |
| p_exp | output | WE | Result biased exponent |
| p_man | output | WM | Result mantissa, 0.1xxx |
| ovf_flag | output | 1 | Result saturated to the largest magnitude |
| unf_flag | output | 1 | Result flushed to zero |

## Verification
The main bench instance is built with WE = 4 and WM = 6, so the bias is 7 and every 12-bit product can be worked out by hand. At that size the vectors reach both ends of the exponent range, exact rounding ties with odd and even LSBs, and the rounding carry that lifts an exponent either into overflow or back out of underflow. A second instance keeps the defaults (WE = 8, WM = 24) and confirms that the shift path and the bias scale with the parameters.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  // outcome of the range test in the last stage
  typedef enum logic [1:0] {
    FPM_NORMAL = 2'd0,
    FPM_ZERO   = 2'd1,
    FPM_OVF    = 2'd2,
    FPM_UNF    = 2'd3
  } fpm_class_e;
endpackage

// File: rtl/fpm_stage_in.sv
module fpm_stage_in #(
  parameter int WE = 8,
  parameter int WM = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WE+WM:0]    op_a,
  input  logic [WE+WM:0]    op_b,
  output logic              s1_valid,
  output logic              s1_sign,
  output logic [WE+1:0]     s1_esum,
  output logic              s1_zero,
  output logic [WM-1:0]     s1_ma,
  output logic [WM-1:0]     s1_mb
);
  logic [WE-1:0] ea, eb;
  logic [WM-1:0] ma, mb;

  assign ea = op_a[WM +: WE];
  assign eb = op_b[WM +: WE];
  assign ma = op_a[WM-1:0];
  assign mb = op_b[WM-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_esum  <= '0;
      s1_zero  <= 1'b0;
      s1_ma    <= '0;
      s1_mb    <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_sign  <= op_a[WE+WM] ^ op_b[WE+WM];
      s1_esum  <= {2'b00, ea} + {2'b00, eb};
      s1_zero  <= (~|ma) | (~|mb);
      s1_ma    <= ma;
      s1_mb    <= mb;
    end
  end
endmodule

// File: rtl/fpm_stage_mul.sv
module fpm_stage_mul #(
  parameter int WE = 8,
  parameter int WM = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_valid,
  input  logic                 s1_sign,
  input  logic [WE+1:0]        s1_esum,
  input  logic                 s1_zero,
  input  logic [WM-1:0]        s1_ma,
  input  logic [WM-1:0]        s1_mb,
  output logic                 s2_valid,
  output logic                 s2_sign,
  output logic                 s2_zero,
  output logic signed [WE+1:0] s2_exp,
  output logic [2*WM-1:0]      s2_prod
);
  localparam int EW = WE + 2;
  localparam int PW = 2 * WM;
  localparam logic signed [EW-1:0] BIAS_S = EW'((1 << (WE - 1)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_sign  <= 1'b0;
      s2_zero  <= 1'b0;
      s2_exp   <= '0;
      s2_prod  <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_sign  <= s1_sign;
      s2_zero  <= s1_zero;
      s2_exp   <= $signed(s1_esum) - BIAS_S;
      s2_prod  <= PW'(s1_ma) * PW'(s1_mb);
    end
  end
endmodule

// File: rtl/fpm_stage_norm.sv
module fpm_stage_norm
  import fpm_pkg::*;
#(
  parameter int WE = 8,
  parameter int WM = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s2_valid,
  input  logic                 s2_sign,
  input  logic                 s2_zero,
  input  logic signed [WE+1:0] s2_exp,
  input  logic [2*WM-1:0]      s2_prod,
  output logic                 out_valid,
  output logic                 p_sign,
  output logic [WE-1:0]        p_exp,
  output logic [WM-1:0]        p_man,
  output logic                 ovf_flag,
  output logic                 unf_flag
);
  localparam int EW = WE + 2;
  localparam int PW = 2 * WM;
  localparam logic signed [EW-1:0] ONE_S  = EW'(1);
  localparam logic signed [EW-1:0] EMAX_S = EW'((1 << WE) - 1);

  // normalize by at most one place, then round to nearest even
  function automatic logic [EW+WM-1:0] norm_round(input logic [PW-1:0] prod,
                                                   input logic signed [EW-1:0] e);
    logic [PW-1:0]          nrm;
    logic signed [EW-1:0]   ex;
    logic [WM:0]            kept;
    logic                   g, r, st, up;
    if (prod[PW-1]) begin
      nrm = prod;
      ex  = e;
    end else begin
      nrm = prod << 1;
      ex  = e - ONE_S;
    end
    kept = {1'b0, nrm[PW-1 -: WM]};
    g    = nrm[WM-1];
    r    = nrm[WM-2];
    st   = |nrm[WM-3:0];
    up   = g & (r | st | kept[0]);
    kept = kept + {{WM{1'b0}}, up};
    if (kept[WM]) begin
      kept = {2'b01, {(WM-1){1'b0}}};
      ex   = ex + ONE_S;
    end
    return {ex, kept[WM-1:0]};
  endfunction

  logic [EW+WM-1:0]     nr;
  logic signed [EW-1:0] nr_exp;
  logic [WM-1:0]        nr_man;
  fpm_class_e           nr_class;

  assign nr     = norm_round(s2_prod, s2_exp);
  assign nr_exp = $signed(nr[WM +: EW]);
  assign nr_man = nr[WM-1:0];

  always_comb begin
    if (s2_zero)                nr_class = FPM_ZERO;
    else if (nr_exp > EMAX_S)   nr_class = FPM_OVF;
    else if (nr_exp[EW-1])      nr_class = FPM_UNF;
    else                        nr_class = FPM_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      p_sign    <= 1'b0;
      p_exp     <= '0;
      p_man     <= '0;
      ovf_flag  <= 1'b0;
      unf_flag  <= 1'b0;
    end else begin
      out_valid <= s2_valid;
      ovf_flag  <= s2_valid && (nr_class == FPM_OVF);
      unf_flag  <= s2_valid && (nr_class == FPM_UNF);
      case (nr_class)
        FPM_NORMAL: begin
          p_sign <= s2_sign;
          p_exp  <= nr_exp[WE-1:0];
          p_man  <= nr_man;
        end
        FPM_OVF: begin
          p_sign <= s2_sign;
          p_exp  <= '1;
          p_man  <= '1;
        end
        default: begin
          p_sign <= 1'b0;
          p_exp  <= '0;
          p_man  <= '0;
        end
      endcase
    end
  end

  AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> (&p_exp) && (&p_man)); // R7
  AST_UNF_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |-> (p_exp == '0) && (p_man == '0) && !p_sign); // R8
  AST_MAN_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (p_man == '0) || p_man[WM-1]); // R3
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag || unf_flag) |-> out_valid); // R10
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ovf_flag, unf_flag}) <= 1); // R10
endmodule

// File: rtl/fpm_mult.sv
module fpm_mult #(
  parameter int WE = 8,
  parameter int WM = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [WE+WM:0]  op_a,
  input  logic [WE+WM:0]  op_b,
  output logic            out_valid,
  output logic            p_sign,
  output logic [WE-1:0]   p_exp,
  output logic [WM-1:0]   p_man,
  output logic            ovf_flag,
  output logic            unf_flag
);
  logic                 s1_valid, s1_sign, s1_zero;
  logic [WE+1:0]        s1_esum;
  logic [WM-1:0]        s1_ma, s1_mb;
  logic                 s2_valid, s2_sign, s2_zero;
  logic signed [WE+1:0] s2_exp;
  logic [2*WM-1:0]      s2_prod;
  logic                 in_has_zero;

  assign in_has_zero = (op_a[WM-1:0] == '0) || (op_b[WM-1:0] == '0);

  fpm_stage_in #(.WE(WE), .WM(WM)) u_in (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_esum(s1_esum),
    .s1_zero(s1_zero), .s1_ma(s1_ma), .s1_mb(s1_mb));

  fpm_stage_mul #(.WE(WE), .WM(WM)) u_mul (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_sign(s1_sign),
    .s1_esum(s1_esum), .s1_zero(s1_zero), .s1_ma(s1_ma), .s1_mb(s1_mb),
    .s2_valid(s2_valid), .s2_sign(s2_sign), .s2_zero(s2_zero),
    .s2_exp(s2_exp), .s2_prod(s2_prod));

  fpm_stage_norm #(.WE(WE), .WM(WM)) u_norm (
    .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_sign(s2_sign),
    .s2_zero(s2_zero), .s2_exp(s2_exp), .s2_prod(s2_prod),
    .out_valid(out_valid), .p_sign(p_sign), .p_exp(p_exp), .p_man(p_man),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag));

  AST_THREE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid); // R1
  AST_THREE_CYCLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid); // R1
  AST_ZERO_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_has_zero) |-> ##3 (!ovf_flag && !unf_flag && p_exp == '0 && p_man == '0)); // R9
endmodule

// File: tb/fpm_mult_tb.sv
`timescale 1ns/1ps
module fpm_mult_tb;
  localparam int TWE = 4;
  localparam int TWM = 6;
  localparam int TW  = 1 + TWE + TWM;
  localparam int NV  = 17;

  typedef struct packed {
    logic            v;
    logic [TW-1:0]   a;
    logic [TW-1:0]   b;
    logic            es;
    logic [TWE-1:0]  ee;
    logic [TWM-1:0]  em;
    logic            eo;
    logic            eu;
    logic [3:0]      rq;
  } vec_t;

  // bias 7; products worked out by hand on 12-bit mantissa products
  localparam vec_t VECS [NV] = '{
    '{1'b1, {1'b0,4'd7,6'd32},  {1'b0,4'd7,6'd32},  1'b0, 4'd6,  6'd32, 1'b0, 1'b0, 4'd3},  // R3 shift path
    '{1'b1, {1'b1,4'd8,6'd63},  {1'b0,4'd9,6'd63},  1'b1, 4'd10, 6'd62, 1'b0, 1'b0, 4'd2},  // R2 sign
    '{1'b1, {1'b1,4'd7,6'd47},  {1'b1,4'd7,6'd47},  1'b0, 4'd7,  6'd35, 1'b0, 1'b0, 4'd5},  // R5 round up
    '{1'b1, {1'b0,4'd7,6'd48},  {1'b0,4'd7,6'd62},  1'b0, 4'd7,  6'd46, 1'b0, 1'b0, 4'd5},  // R5 tie, even kept
    '{1'b1, {1'b0,4'd7,6'd48},  {1'b1,4'd7,6'd58},  1'b1, 4'd7,  6'd44, 1'b0, 1'b0, 4'd5},  // R5 tie, odd up
    '{1'b0, {1'b0,4'd0,6'd0},   {1'b0,4'd0,6'd0},   1'b0, 4'd0,  6'd0,  1'b0, 1'b0, 4'd1},  // R1 bubble
    '{1'b1, {1'b0,4'd10,6'd33}, {1'b0,4'd3,6'd33},  1'b0, 4'd5,  6'd34, 1'b0, 1'b0, 4'd4},  // R4 upper bits
    '{1'b1, {1'b0,4'd7,6'd33},  {1'b0,4'd7,6'd62},  1'b0, 4'd7,  6'd32, 1'b0, 1'b0, 4'd6},  // R6 carry out
    '{1'b1, {1'b0,4'd15,6'd33}, {1'b1,4'd8,6'd62},  1'b1, 4'd15, 6'd63, 1'b1, 1'b0, 4'd6},  // R6 carry to ovf
    '{1'b1, {1'b1,4'd15,6'd32}, {1'b0,4'd15,6'd32}, 1'b1, 4'd15, 6'd63, 1'b1, 1'b0, 4'd7},  // R7 overflow
    '{1'b1, {1'b0,4'd15,6'd63}, {1'b0,4'd7,6'd63},  1'b0, 4'd15, 6'd62, 1'b0, 1'b0, 4'd7},  // R7 top edge
    '{1'b1, {1'b1,4'd0,6'd63},  {1'b0,4'd0,6'd63},  1'b0, 4'd0,  6'd0,  1'b0, 1'b1, 4'd8},  // R8 underflow
    '{1'b1, {1'b0,4'd0,6'd32},  {1'b0,4'd7,6'd32},  1'b0, 4'd0,  6'd0,  1'b0, 1'b1, 4'd8},  // R8 via shift
    '{1'b1, {1'b0,4'd0,6'd63},  {1'b0,4'd7,6'd63},  1'b0, 4'd0,  6'd62, 1'b0, 1'b0, 4'd8},  // R8 bottom edge
    '{1'b1, {1'b0,4'd0,6'd33},  {1'b0,4'd7,6'd62},  1'b0, 4'd0,  6'd32, 1'b0, 1'b0, 4'd6},  // R6 rescued
    '{1'b1, {1'b1,4'd0,6'd0},   {1'b0,4'd0,6'd63},  1'b0, 4'd0,  6'd0,  1'b0, 1'b0, 4'd9},  // R9 low exps
    '{1'b1, {1'b0,4'd15,6'd63}, {1'b1,4'd15,6'd0},  1'b0, 4'd0,  6'd0,  1'b0, 1'b0, 4'd9}   // R9 high exps
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [TW-1:0]   op_a = '0, op_b = '0;
  logic            out_valid, p_sign, ovf_flag, unf_flag;
  logic [TWE-1:0]  p_exp;
  logic [TWM-1:0]  p_man;

  logic            w_valid = 1'b0;
  logic [32:0]     w_a = '0, w_b = '0;
  logic            w_ovalid, w_sign, w_ovf, w_unf;
  logic [7:0]      w_exp;
  logic [23:0]     w_man;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fpm_mult #(.WE(TWE), .WM(TWM)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .p_sign(p_sign), .p_exp(p_exp), .p_man(p_man),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag));

  fpm_mult #(.WE(8), .WM(24)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(w_valid), .op_a(w_a), .op_b(w_b),
    .out_valid(w_ovalid), .p_sign(w_sign), .p_exp(w_exp), .p_man(w_man),
    .ovf_flag(w_ovf), .unf_flag(w_unf));

  function automatic string rq_name(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "reset outputs", 64'({out_valid, p_sign, p_exp, p_man, ovf_flag, unf_flag}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "idle after reset", 64'({out_valid, ovf_flag, unf_flag}), 64'd0);

    // back-to-back walk; vector k appears at the negedge three cycles later (R1)
    for (int k = 0; k < NV + 3; k++) begin
      if (k >= 3) begin
        if (VECS[k-3].v)
          check(rq_name(VECS[k-3].rq), $sformatf("vector %0d", k - 3),
                64'({out_valid, p_sign, p_exp, p_man, ovf_flag, unf_flag}),
                64'({1'b1, VECS[k-3].es, VECS[k-3].ee, VECS[k-3].em, VECS[k-3].eo, VECS[k-3].eu}));
        else
          check(rq_name(VECS[k-3].rq), $sformatf("vector %0d bubble", k - 3),
                64'({out_valid, ovf_flag, unf_flag}), 64'd0);
      end
      if (k < NV) begin
        in_valid = VECS[k].v;
        op_a     = VECS[k].a;
        op_b     = VECS[k].b;
      end else begin
        in_valid = 1'b0;
        op_a     = '0;
        op_b     = '0;
      end
      @(negedge clk);
    end

    // R10 reset mid-stream drops an overflowing operation in flight
    in_valid = 1'b1;
    op_a = VECS[9].a;
    op_b = VECS[9].b;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "reset mid-stream", 64'({out_valid, ovf_flag, unf_flag, p_exp, p_man}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "no late flag after reset", 64'({out_valid, ovf_flag, unf_flag}), 64'd0);

    // R3 default widths: 0.5*2^0 times 0.75*2^3 gives 0.75*2^2 through the shift path
    w_valid = 1'b1;
    w_a = {1'b0, 8'd127, 24'h800000};
    w_b = {1'b0, 8'd130, 24'hC00000};
    @(negedge clk);
    w_valid = 1'b0;
    w_a = '0;
    w_b = '0;
    @(negedge clk);
    @(negedge clk);
    check("R3", "wide product", 64'({w_ovalid, w_sign, w_exp, w_man, w_ovf, w_unf}),
          64'({1'b1, 1'b0, 8'd129, 24'hC00000, 1'b0, 1'b0}));

    finish_run();
  end
endmodule